// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

A clocked, synthesizable model of a 16-bit asynchronous static RAM whose controls are all active low: chip select, output enable, write strobe, and one enable for each byte lane. On every modelling clock edge the control pins are decoded into one of four modes: standby, selected-but-quiet, read and write. Writes update only the byte lanes whose enable is low. Reads present only the enabled lanes.

The tristate bus is split into a write-data input, a read-data output and one drive flag per byte lane. A flag of 1 means the lane is driving. A flag of 0 stands for a floating lane. Whatever integrates the model can resolve these signals into a real bus. The address is 18 bits wide. The stored depth is a power-of-two parameter, and the word index is the address modulo that depth, so a test can run on a small array.

Top module: `bytelane_sram`

## Requirements
- R1: While and right after reset, `dq_oe` is 2'b00 and `dout` is all zero.
- R2: With `cs_n` high, the flags are 2'b00 one edge later, and nothing is written whatever the other pins are.
- R3: With `cs_n` low and both `oe_n` and `we_n` high, the flags are 2'b00 one edge later and memory is unchanged.
- R4: With `cs_n` and `we_n` low at an edge, `din[7:0]` is stored at the addressed word only if `lb_n` is low, and `din[15:8]` only if `ub_n` is low. A lane whose enable is high keeps its old contents.
- R5: The write strobe overrides output enable. After an edge with `cs_n` and `we_n` low, the flags are 2'b00 even if `oe_n` is low.
- R6: With `cs_n` and `oe_n` low and `we_n` high at an edge, `dq_oe[0]` equals the inverse of `lb_n` and `dq_oe[1]` the inverse of `ub_n` after that edge. A driving lane shows the stored byte. If both enables are high, the flags are 2'b00.
- R7: A lane whose drive flag is 0 shows zero on its `dout` bits (bits 7:0 for lane 0, bits 15:8 for lane 1).
- R8: The word index is `addr` modulo `DEPTH`. Addresses that differ by a multiple of `DEPTH` reach the same word.
- R9: Read data and flags are registered and appear one edge after the inputs are sampled. A read one cycle after a write to the same word returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modelling clock; every mode is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; overrides `oe_n` |
| lb_n | input | 1 | Lane 0 (bits 7:0) enable, active low |
| ub_n | input | 1 | Lane 1 (bits 15:8) enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Registered read data; zero in lanes that are not driving |
| dq_oe | output | 2 | Per-lane drive flags; bit 0 for lane 0, bit 1 for lane 1 |

## Verification
Every result of the block is due exactly one rising edge after its inputs are sampled. The memory update happens at that same edge, and the read data and drive flags are registered at it. The bench changes inputs on the falling edge and inspects the outputs shortly after the following rising edge. Each check therefore sees the result of exactly one set of inputs. The effects of writes and of ignored writes are observed through reads in later cycles, and these are compared against a masked shadow copy held in the bench.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_QUIET   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } sram_mode_e;

endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_model_pkg::*;
(
  input  logic             cs_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [LANES-1:0] lane_en_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd
);

  always_comb begin
    if (cs_n)      mode = MODE_STANDBY;
    else if (!we_n) mode = MODE_WRITE;
    else if (oe_n)  mode = MODE_QUIET;
    else            mode = MODE_READ;
  end

  assign lane_wr = (mode == MODE_WRITE) ? ~lane_en_n : '0;
  assign lane_rd = (mode == MODE_READ)  ? ~lane_en_n : '0;

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int DEPTH  = 4096,
  parameter int LANE_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata,
  output logic              drive
);

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] rd_q;
  logic              drive_q;

  // Plain array with registered, read-first port: infers one block RAM per lane
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    rd_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= rd_en;
  end

  assign drive = drive_q;
  assign rdata = drive_q ? rd_q : '0;

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DEPTH  = 4096,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  dq_oe
);

  sram_mode_e       mode;
  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] lane_rd;
  logic [IDX_W-1:0] idx;

  // Power-of-two depth: truncation gives addr modulo DEPTH
  assign idx = IDX_W'(addr);

  sram_ctrl_decode u_dec (
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .lane_en_n ({ub_n, lb_n}),
    .mode      (mode),
    .lane_wr   (lane_wr),
    .lane_rd   (lane_rd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .wr_en (lane_wr[g]),
      .rd_en (lane_rd[g]),
      .idx   (idx),
      .wdata (din[g*LANE_W +: LANE_W]),
      .rdata (dout[g*LANE_W +: LANE_W]),
      .drive (dq_oe[g])
    );
  end

endmodule

// File: rtl/bytelane_sram_chk.sv
module bytelane_sram_chk
  import sram_model_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic [DATA_W-1:0] dout,
  input logic [LANES-1:0]  dq_oe
);

  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (dq_oe == 2'b00));

  // R3
  selected_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && oe_n && we_n) |=> (dq_oe == 2'b00));

  // R5
  write_blocks_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !we_n) |=> (dq_oe == 2'b00));

  // R6
  read_low_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !oe_n && we_n) |=> (dq_oe[0] == !$past(lb_n)));

  // R6
  read_high_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !oe_n && we_n) |=> (dq_oe[1] == !$past(ub_n)));

  // R7
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((dq_oe[0] || dout[7:0] == '0) && (dq_oe[1] || dout[15:8] == '0)));

  // R1
  reset_release_chk: assert property (@(posedge clk)
    $past(rst) |-> (dq_oe == 2'b00 && dout == '0));

endmodule

bind bytelane_sram bytelane_sram_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (cs_n),
  .oe_n  (oe_n),
  .we_n  (we_n),
  .lb_n  (lb_n),
  .ub_n  (ub_n),
  .dout  (dout),
  .dq_oe (dq_oe)
);

// File: tb/bytelane_sram_test.sv
`timescale 1ns/1ps
module bytelane_sram_test;

  localparam int ADDR_W = 18;
  localparam int DEPTH  = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       din = '0;
  logic [15:0]       dout;
  logic [1:0]        dq_oe;

  logic [7:0] sh_lo [DEPTH];
  logic [7:0] sh_hi [DEPTH];

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  bytelane_sram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .din(din),
    .dout(dout), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, look 1 ns after the next rising edge
  task automatic step(input logic c, input logic o, input logic w, input logic l,
                      input logic u, input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_n = c; oe_n = o; we_n = w; lb_n = l; ub_n = u; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic read_chk(input string req, input int a, input logic l, input logic u);
    logic [15:0] exp_d;
    step(1'b0, 1'b0, 1'b1, l, u, ADDR_W'(a), 16'h0);
    exp_d = {(!u ? sh_hi[a % DEPTH] : 8'h00), (!l ? sh_lo[a % DEPTH] : 8'h00)};
    check(req, {dq_oe, dout}, {~u, ~l, exp_d});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", {dq_oe, dout}, 18'h0);
    @(negedge clk);
    rst = 1'b0;

    // R4: fill every word with both lanes enabled
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ADDR_W'(a), 16'((a * 16'h0101) ^ 16'h5AC3));
      sh_lo[a] = 8'(a ^ 8'hC3);
      sh_hi[a] = 8'(a ^ 8'h5A);
    end

    // R4 / R5: masked writes sweeping the lane enables, oe_n low on half of them
    for (int a = 0; a < DEPTH; a++) begin
      logic l, u, o;
      logic [15:0] d;
      l = a[0]; u = a[1]; o = a[2];
      d = 16'((a * 16'h0B17) + 16'h1234);
      step(1'b0, o, 1'b0, l, u, ADDR_W'(a), d);
      check("R5", {16'h0, dq_oe}, 18'h0);
      if (!l) sh_lo[a] = d[7:0];
      if (!u) sh_hi[a] = d[15:8];
    end

    // R6 / R7 / R4: read every word under all four lane-enable patterns
    for (int a = 0; a < DEPTH; a++)
      for (int e = 0; e < 4; e++)
        read_chk("R6", a, e[0], e[1]);

    // R2: standby with every other pin asking for a write
    for (int a = 0; a < 16; a++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, ADDR_W'(a), 16'hDEAD);
      check("R2", {16'h0, dq_oe}, 18'h0);
    end
    for (int a = 0; a < 16; a++) read_chk("R2", a, 1'b0, 1'b0);

    // R3: selected, outputs and strobe off
    for (int a = 16; a < 32; a++) begin
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, ADDR_W'(a), 16'hBEEF);
      check("R3", {dq_oe, dout}, 18'h0);
    end
    for (int a = 16; a < 32; a++) read_chk("R3", a, 1'b0, 1'b0);

    // R4: write with both lanes disabled leaves the word alone
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ADDR_W'(40), 16'hFFFF);
    read_chk("R4", 40, 1'b0, 1'b0);

    // R8: an address above DEPTH aliases onto addr mod DEPTH
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ADDR_W'(DEPTH * 3 + 5), 16'hA55A);
    sh_lo[5] = 8'h5A; sh_hi[5] = 8'hA5;
    read_chk("R8", 5, 1'b0, 1'b0);
    read_chk("R8", DEPTH * 1000 + 5, 1'b0, 1'b0);

    // R9: write then read the same word in back-to-back cycles
    for (int k = 0; k < 8; k++) begin
      logic [15:0] d;
      d = 16'(16'h3C00 + k * 16'h0111);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, ADDR_W'(100 + k), d);
      sh_lo[100 + k] = d[7:0]; sh_hi[100 + k] = d[15:8];
      read_chk("R9", 100 + k, 1'b0, 1'b0);
    end

    // R1: reset again drops the drive flags
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ADDR_W'(7), 16'h0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1", {dq_oe, dout}, 18'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule